// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block conditions a bank of asynchronous input pins before internal logic uses them. Each pin has a 2-bit mode. The mode selects one of four treatments: a plain two-stage synchronizer, a glitch filter that needs 3 agreeing samples, a glitch filter that needs 6 agreeing samples, or a raw unsynchronized pass-through for consumers that synchronize on their own.

Pins are grouped eight at a time. Each group has one 8-bit period value, and that value sets how far apart the filter samples are taken for every pin in the group. A filtered pin changes its output only on a sample strobe where the newest samples of its window all agree. Otherwise the pin keeps its last qualified level. Configuration is supplied on plain input ports.

Top module: `gpio_qual_filter`

## Requirements
- R1: While reset is asserted (synchronous, active low), every synchronizer stage, every sample history and every qualified level clears to 0. With all modes at code 00, every output reads 0.
- R2: Mode code 00 drives the output from a two-flip-flop synchronizer. An input change that is applied after the falling clock edge appears on the output after the second rising edge that follows.
- R3: Mode code 11 drives the output combinationally from the raw pin, with no register on the path.
- R4: Mode code 01 selects a 3-sample window. With period 0, a level held on the pin appears on the output after the fifth rising edge that follows the change.
- R5: Mode code 10 selects a 6-sample window. With period 0, a held level appears on the output after the eighth rising edge.
- R6: In either window mode the output keeps its previous value unless the newest 3 or 6 samples are all 0 or all 1. A pulse that yields fewer agreeing samples than the window length is rejected.
- R7: A group period of 0 takes one sample every clock. A period of n>0 takes one sample every 2·n clocks. For a 3-sample window this gives an acceptance latency between 4·n+3 and 6·n+2 clocks after the pin changes.
- R8: Pins 0-7 use period field bits [7:0] and pins 8-15 use bits [15:8]. The period of one group does not affect the sampling of the other group.
- R9: Sample history shifts on every strobe in every mode and is not cleared when a pin's mode changes. A pin switched into a window mode whose stored history already agrees updates its output on the first strobe after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | NUM_PINS | Asynchronous pin levels |
| mode_sel | input | 2*NUM_PINS | Per-pin mode, pin i at bits [2i+1:2i] |
| group_period | input | PERIOD_W*NUM_GROUPS | Per-group sample period, group g at bits [8g+7:8g] |
| pin_qual | output | NUM_PINS | Qualified pin levels |

## Verification
A broken synchronizer chain shows on the first edge change in mode 00, because the output moves one clock early or late. A sample history that shifts on the wrong strobe, or a window that compares the wrong bits, moves the acceptance edge of a filtered pin away from the fifth or eighth clock. It also lets a short pulse through within a few clocks. A history that is wrongly flushed on a mode change shows on the very first strobe after the switch. A period counter with the wrong terminal count pushes acceptance outside the window of 4·n+3 to 6·n+2 clocks.

// File: rtl/gpq_pkg.sv
// Shared definitions for the GPIO input qualification filter.
package gpq_pkg;

    // Per-pin qualification mode; the codes are decoded by the pin filter.
    typedef enum logic [1:0] {
        QM_SYNC = 2'b00,
        QM_WIN3 = 2'b01,
        QM_WIN6 = 2'b10,
        QM_RAW  = 2'b11
    } qual_mode_e;

endpackage

// File: rtl/gpq_strobe_gen.sv
// Sample strobe generator for one pin group.
// Assumes: period 0 gives a strobe every clock, and period n gives one every
// 2*n clocks. A reduced period takes effect at once because the compare uses >=.
module gpq_strobe_gen #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                strobe_o
);
    localparam int CNT_W = PERIOD_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the current period setting.
    always_comb begin
        if (period_i == '0) limit = '0;
        else                limit = ({1'b0, period_i} << 1) - CNT_W'(1);
    end

    assign strobe_o = (cnt_q >= limit);

    // Count up between strobes and restart on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (strobe_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + CNT_W'(1);
    end

    // R7: with a non-zero period, two strobes are never adjacent.
    p_strobe_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && period_i != '0) |=> (period_i == '0 || !strobe_o));

endmodule

// File: rtl/gpq_sync_chain.sv
// Multi-stage synchronizer for one asynchronous pin.
// Assumes STAGES >= 2. All stages clear on reset.
module gpq_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] st_q;

    // Shift the pin level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= {st_q[STAGES-2:0], d_i};
    end

    assign q_o = st_q[STAGES-1];

    // R2: each stage takes the value of the one before it on the previous clock.
    p_chain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q[1] == $past(st_q[0])));

endmodule

// File: rtl/gpq_pin_filter.sv
// Qualification for one pin: synchronizer, sample history, window check and mode mux.
// Assumes strobe_i comes from the strobe generator of the pin's group.
// The history shifts on every strobe whatever the mode. The qualified level
// updates only on a strobe in a window mode.
module gpq_pin_filter
    import gpq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_WIN   = 3,
    parameter int LONG_WIN    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_i,
    input  logic       strobe_i,
    input  logic [1:0] mode_i,
    output logic       pin_o
);
    qual_mode_e mode;
    logic synced;
    logic [LONG_WIN-1:0] hist_q;
    logic [LONG_WIN-1:0] hist_nxt;
    logic short_one, short_zero, long_one, long_zero;
    logic win_hit;
    logic qual_q;

    assign mode = qual_mode_e'(mode_i);

    gpq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_i),
        .q_o   (synced)
    );

    assign hist_nxt   = {hist_q[LONG_WIN-2:0], synced};
    assign short_one  = &hist_nxt[SHORT_WIN-1:0];
    assign short_zero = ~|hist_nxt[SHORT_WIN-1:0];
    assign long_one   = &hist_nxt[LONG_WIN-1:0];
    assign long_zero  = ~|hist_nxt[LONG_WIN-1:0];

    // Decide whether the window of the current mode agrees.
    always_comb begin
        case (mode)
            QM_WIN3: win_hit = short_one | short_zero;
            QM_WIN6: win_hit = long_one | long_zero;
            default: win_hit = 1'b0;
        endcase
    end

    // Shift the synchronized level into the history on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (strobe_i) hist_q <= hist_nxt;
    end

    // Take the agreed level when the window is unanimous.
    always_ff @(posedge clk) begin
        if (!rst_n)                   qual_q <= 1'b0;
        else if (strobe_i && win_hit) qual_q <= hist_nxt[0];
    end

    // Pick the output path for the pin's mode.
    always_comb begin
        case (mode)
            QM_SYNC: pin_o = synced;
            QM_RAW:  pin_o = raw_i;
            default: pin_o = qual_q;
        endcase
    end

    // R6: the qualified level moves only on a strobe.
    p_hold_off_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(qual_q));

    // R4: a change made in 3-sample mode is backed by 3 agreeing samples.
    p_short_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && qual_q != $past(qual_q) && $past(mode_i) == QM_WIN3)
        |-> (hist_q[SHORT_WIN-1:0] == {SHORT_WIN{qual_q}}));

    // R5: a change made in 6-sample mode is backed by 6 agreeing samples.
    p_long_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && qual_q != $past(qual_q) && $past(mode_i) == QM_WIN6)
        |-> (hist_q == {LONG_WIN{qual_q}}));

    // R9: the history takes the synchronized level on every strobe, in any mode.
    p_hist_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(strobe_i)) |-> (hist_q[0] == $past(synced)));

endmodule

// File: rtl/gpio_qual_filter.sv
// Bank of qualified GPIO inputs: one strobe generator per group of pins and
// one filter per pin.
// Assumes mode_sel holds 2 bits per pin and group_period holds PERIOD_W bits
// per group, both packed from the lowest index up.
module gpio_qual_filter #(
    parameter int  NUM_PINS    = 16,
    parameter int  GROUP_SIZE  = 8,
    parameter int  PERIOD_W    = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int NUM_GROUPS  = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pin_raw,
    input  logic [2*NUM_PINS-1:0]          mode_sel,
    input  logic [PERIOD_W*NUM_GROUPS-1:0] group_period,
    output logic [NUM_PINS-1:0]            pin_qual
);
    logic [NUM_GROUPS-1:0] grp_strobe;

    // One sample strobe per group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gpq_strobe_gen #(.PERIOD_W(PERIOD_W)) u_strobe (
            .clk      (clk),
            .rst_n    (rst_n),
            .period_i (group_period[g*PERIOD_W +: PERIOD_W]),
            .strobe_o (grp_strobe[g])
        );
    end

    // One filter per pin, fed by its group's strobe.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int GIDX = i / GROUP_SIZE;
        gpq_pin_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .SHORT_WIN   (3),
            .LONG_WIN    (6)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (pin_raw[i]),
            .strobe_i (grp_strobe[GIDX]),
            .mode_i   (mode_sel[2*i +: 2]),
            .pin_o    (pin_qual[i])
        );
    end

endmodule

// File: tb/gpio_qual_filter_tb_top.sv
module gpio_qual_filter_tb_top;
    localparam int NP = 16;
    localparam int PW = 8;
    localparam int NG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] pin_raw = '0;
    logic [2*NP-1:0] mode_sel = '0;
    logic [PW*NG-1:0] group_period = '0;
    logic [NP-1:0] pin_qual;

    gpio_qual_filter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_raw      (pin_raw),
        .mode_sel     (mode_sel),
        .group_period (group_period),
        .pin_qual     (pin_qual)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    pin;
        logic  val;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Driver side: queue an expected output level, kept sorted by cycle.
    task automatic expect_at(int off, int pin, logic val, string tag);
        exp_t e;
        int idx;
        e.at = cyc + off; e.pin = pin; e.val = val; e.tag = tag;
        idx = sbq.size();
        for (int k = 0; k < sbq.size(); k++) begin
            if (sbq[k].at > e.at) begin idx = k; break; end
        end
        sbq.insert(idx, e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
        #1;
    endtask

    task automatic set_mode(int pin, logic [1:0] m);
        mode_sel[2*pin +: 2] = m;
    endtask

    // Monitor: compare due items on the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (pin_qual[e.pin] !== e.val || e.at != cyc) begin
                fails++;
                $display("FAIL %s pin %0d cycle %0d: actual=%b expected=%b",
                         e.tag, e.pin, cyc, pin_qual[e.pin], e.val);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state while the pins are driven high.
        pin_raw = '1;
        step(2);
        expect_at(1, 0, 1'b0, "R1");
        expect_at(1, 7, 1'b0, "R1");
        expect_at(1, 15, 1'b0, "R1");
        drain();

        // R2: two-flop synchronizer latency, rising and falling.
        rst_n = 1'b1;
        expect_at(1, 3, 1'b0, "R2");
        expect_at(2, 3, 1'b1, "R2");
        expect_at(2, 12, 1'b1, "R2");
        drain();
        pin_raw[3] = 1'b0;
        expect_at(1, 3, 1'b1, "R2");
        expect_at(2, 3, 1'b0, "R2");
        drain();

        // R3: raw pass-through follows the pin without a register.
        set_mode(5, 2'b11);
        pin_raw[5] = 1'b0;
        expect_at(1, 5, 1'b0, "R3");
        drain();
        pin_raw[5] = 1'b1;
        expect_at(1, 5, 1'b1, "R3");
        drain();

        // Settle the window pins low.
        pin_raw = '0;
        set_mode(1, 2'b01);
        set_mode(2, 2'b10);
        set_mode(9, 2'b01);
        step(12);

        // R4 / R5: acceptance latency with period 0.
        pin_raw[1] = 1'b1; pin_raw[2] = 1'b1;
        expect_at(4, 1, 1'b0, "R4");
        expect_at(5, 1, 1'b1, "R4");
        expect_at(7, 2, 1'b0, "R5");
        expect_at(8, 2, 1'b1, "R5");
        drain();
        step(4);
        pin_raw[1] = 1'b0; pin_raw[2] = 1'b0;
        expect_at(4, 1, 1'b1, "R4");
        expect_at(5, 1, 1'b0, "R4");
        expect_at(7, 2, 1'b1, "R5");
        expect_at(8, 2, 1'b0, "R5");
        drain();
        step(8);

        // R6: a 2-clock pulse is rejected by both windows.
        pin_raw[1] = 1'b1; pin_raw[2] = 1'b1;
        expect_at(5, 1, 1'b0, "R6");
        expect_at(6, 1, 1'b0, "R6");
        expect_at(9, 1, 1'b0, "R6");
        expect_at(8, 2, 1'b0, "R6");
        step(2);
        pin_raw[1] = 1'b0; pin_raw[2] = 1'b0;
        drain();
        step(6);

        // R6: a 5-clock pulse passes the 3-sample window only.
        pin_raw[1] = 1'b1; pin_raw[2] = 1'b1;
        expect_at(5, 1, 1'b1, "R6");
        expect_at(8, 2, 1'b0, "R6");
        expect_at(11, 2, 1'b0, "R6");
        step(5);
        pin_raw[1] = 1'b0; pin_raw[2] = 1'b0;
        drain();
        step(10);

        // R9: the history kept in sync mode is used at once after the switch.
        pin_raw[6] = 1'b1;
        step(12);
        set_mode(6, 2'b01);
        expect_at(1, 6, 1'b1, "R9");
        drain();

        // R7 / R8: group 0 period 3 (one sample every 6 clocks), group 1 period 0.
        group_period[7:0] = 8'd3;
        step(3);
        pin_raw[1] = 1'b1; pin_raw[9] = 1'b1;
        expect_at(14, 1, 1'b0, "R7");
        expect_at(20, 1, 1'b1, "R7");
        expect_at(4, 9, 1'b0, "R8");
        expect_at(5, 9, 1'b1, "R8");
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule